// File: doc/BRIEF.md
# Pulse-Frequency Burst Bridge Controller

This block drives the four gates of a non-inverting buck-boost bridge that runs in pulse-frequency mode. Two comparator flags decide when a burst runs. A burst starts once the output has sagged to its nominal level. It continues, one inductor pulse after another, until the output is above a threshold set 1.5% over nominal. Switching then stops until the output sags again.

Each pulse has two phases. An energising phase runs until the inductor current reaches its peak limit. A freewheel phase runs until the inductor current returns to zero, because the converter runs in discontinuous conduction. The gates used in each phase depend on the buck or boost selection. A fixed number of dead-time clocks separates every change between series switches. The buck/boost choice is sampled only between pulses.

The input leg is A (high) and B (low). The output leg is C (low) and D (high). A/B and C/D are the series pairs. All switch outputs are decoded from registered state only.

Top module: `pfm_burst_ctrl`

## Requirements
- R1: While reset is held, and on the first clock after reset when the selected mode is boost, all four gates are open, burst_active is low and both strobes are low.
- R2: When no burst is running and the controller is between pulses, vout_low high at a clock edge raises burst_active after that edge. The first energising phase starts at the following edge.
- R3: In buck mode (mode_boost=0), D stays closed and C stays open whenever the latched mode is buck. During energising only A is closed on the input leg.
- R4: In buck mode, once ipk_hit is sampled high, A opens and the input leg stays fully open for DT_CYC clocks. B then closes until izero is sampled high.
- R5: In boost mode (mode_boost=1), the energising phase closes A and C and keeps B and D open.
- R6: In boost mode, once ipk_hit is sampled high, all four gates open for DT_CYC clocks. B and D then close until izero is sampled high.
- R7: A and B are never closed together, and C and D are never closed together. A switch never closes on the clock after its series partner opens.
- R8: When izero is sampled high during the freewheel phase, that phase's switches open and pulse_done is high for exactly one clock. The pulse boundary is reached DT_CYC clocks later.
- R9: While burst_active is high and vout_high is low at a pulse boundary, a new energising phase starts at that edge.
- R10: If vout_high is high at a pulse boundary during a burst, burst_active falls and burst_done is high for one clock. No switch outside the buck-mode D switch closes until a new burst starts.
- R11: A change of mode_boost during a pulse has no effect on that pulse. It takes effect at the next boundary and costs DT_CYC clocks in which A, B and C stay open.
- R12: ipk_hit is ignored outside the energising phase, and izero is ignored outside the freewheel phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_boost | input | 1 | 1 selects boost operation, 0 selects buck |
| ipk_hit | input | 1 | Inductor current has reached the peak limit |
| izero | input | 1 | Inductor current has returned to zero |
| vout_high | input | 1 | Output is above the upper threshold (nominal + 1.5%) |
| vout_low | input | 1 | Output is at or below nominal |
| sw_a | output | 1 | Gate of input-leg high switch |
| sw_b | output | 1 | Gate of input-leg low switch |
| sw_c | output | 1 | Gate of output-leg low switch |
| sw_d | output | 1 | Gate of output-leg high switch |
| burst_active | output | 1 | A burst of pulses is in progress |
| pulse_done | output | 1 | One-clock strobe at the end of each pulse |
| burst_done | output | 1 | One-clock strobe when a burst stops |

## Verification
The hardest case to reach from the ports is a mode_boost change that lands in the middle of a pulse and then has to show up at exactly the next boundary, behind a dead-time gap. The stimulus table flips mode_boost during a boost freewheel phase and restores it before the current reaches zero, so any leak into the running pulse shows on the gates. It then changes mode while idle and checks that D closes only after the boundary and stays closed through the buck burst. Stray ipk_hit and izero pulses are placed in the phases that must ignore them, and a reset is applied during an energising phase.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ENERGIZE,
    PH_GAP,
    PH_DEMAG,
    PH_TAIL
  } phase_e;

  // Gate pattern {a, b, c, d} for a latched mode and a pulse phase.
  function automatic logic [3:0] bridge_gates(input logic boost, input phase_e ph);
    logic [3:0] g;
    g = 4'b0000;
    if (boost) begin
      if (ph == PH_ENERGIZE) g = 4'b1010;
      if (ph == PH_DEMAG)    g = 4'b0101;
    end else begin
      g[0] = 1'b1;
      if (ph == PH_ENERGIZE) g[3] = 1'b1;
      if (ph == PH_DEMAG)    g[2] = 1'b1;
    end
    return g;
  endfunction

  // Counter preload giving a dead-time window of dt clocks.
  function automatic int unsigned gap_preload(input int unsigned dt);
    return (dt > 0) ? dt - 1 : 0;
  endfunction

endpackage

// File: rtl/pfm_burst_gate.sv
module pfm_burst_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic at_boundary,
  input  logic vout_high,
  input  logic vout_low,
  output logic burst_active,
  output logic burst_done,
  output logic pulse_go
);

  logic stop_now;
  logic start_now;

  assign start_now = at_boundary && !burst_active && vout_low;
  assign stop_now  = at_boundary && burst_active && vout_high;
  assign pulse_go  = at_boundary && burst_active && !vout_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_active <= 1'b0;
      burst_done   <= 1'b0;
    end else begin
      burst_done <= stop_now;
      if (start_now)     burst_active <= 1'b1;
      else if (stop_now) burst_active <= 1'b0;
    end
  end

  assert_burst_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> !burst_active && $past(vout_high));

  assert_burst_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $past(vout_low));

endmodule

// File: rtl/pfm_pulse_seq.sv
module pfm_pulse_seq
  import pfm_pkg::*;
#(
  parameter int unsigned DT_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mode_boost,
  input  logic   ipk_hit,
  input  logic   izero,
  input  logic   pulse_go,
  output phase_e phase_q,
  output logic   mode_q,
  output logic   at_boundary,
  output logic   pulse_done
);

  localparam int unsigned CW = (DT_CYC < 2) ? 1 : $clog2(DT_CYC);
  localparam logic [CW-1:0] GAP_LOAD = CW'(gap_preload(DT_CYC));

  logic [CW-1:0] gap_cnt;
  logic          gap_over;
  logic          mode_diff;

  assign gap_over    = (gap_cnt == '0);
  assign mode_diff   = (mode_boost != mode_q);
  assign at_boundary = (phase_q == PH_IDLE) && !mode_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      mode_q     <= 1'b1;
      gap_cnt    <= '0;
      pulse_done <= 1'b0;
    end else begin
      pulse_done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (mode_diff) begin
            mode_q  <= mode_boost;
            gap_cnt <= GAP_LOAD;
            phase_q <= PH_TAIL;
          end else if (pulse_go) begin
            phase_q <= PH_ENERGIZE;
          end
        end
        PH_ENERGIZE: begin
          if (ipk_hit) begin
            gap_cnt <= GAP_LOAD;
            phase_q <= PH_GAP;
          end
        end
        PH_GAP: begin
          if (gap_over) phase_q <= PH_DEMAG;
          else          gap_cnt <= gap_cnt - 1'b1;
        end
        PH_DEMAG: begin
          if (izero) begin
            gap_cnt    <= GAP_LOAD;
            pulse_done <= 1'b1;
            phase_q    <= PH_TAIL;
          end
        end
        PH_TAIL: begin
          if (gap_over) phase_q <= PH_IDLE;
          else          gap_cnt <= gap_cnt - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q inside {PH_ENERGIZE, PH_GAP, PH_DEMAG}) |=> $stable(mode_q));

  assert_peak_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ENERGIZE && ipk_hit) |=> (phase_q == PH_GAP));

  assert_pulse_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |-> (phase_q == PH_TAIL) && ($past(phase_q) == PH_DEMAG));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |=> !pulse_done);

endmodule

// File: rtl/pfm_switch_map.sv
module pfm_switch_map
  import pfm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_q,
  input  logic   mode_q,
  output logic   sw_a,
  output logic   sw_b,
  output logic   sw_c,
  output logic   sw_d
);

  logic [3:0] gates;

  assign gates = bridge_gates(mode_q, phase_q);
  assign sw_a  = gates[3];
  assign sw_b  = gates[2];
  assign sw_c  = gates[1];
  assign sw_d  = gates[0];

  assert_pair_ab_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_a && sw_b));

  assert_pair_cd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_c && sw_d));

  assert_dead_ab_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_a) |=> !sw_b) and ($fell(sw_b) |=> !sw_a));

  assert_dead_cd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_c) |=> !sw_d) and ($fell(sw_d) |=> !sw_c));

endmodule

// File: rtl/pfm_burst_ctrl.sv
module pfm_burst_ctrl
  import pfm_pkg::*;
#(
  parameter int unsigned DT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_boost,
  input  logic ipk_hit,
  input  logic izero,
  input  logic vout_high,
  input  logic vout_low,
  output logic sw_a,
  output logic sw_b,
  output logic sw_c,
  output logic sw_d,
  output logic burst_active,
  output logic pulse_done,
  output logic burst_done
);

  phase_e phase_q;
  logic   mode_q;
  logic   at_boundary;
  logic   pulse_go;

  pfm_pulse_seq #(.DT_CYC(DT_CYC)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_boost (mode_boost),
    .ipk_hit    (ipk_hit),
    .izero      (izero),
    .pulse_go   (pulse_go),
    .phase_q    (phase_q),
    .mode_q     (mode_q),
    .at_boundary(at_boundary),
    .pulse_done (pulse_done)
  );

  pfm_burst_gate gate_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .at_boundary (at_boundary),
    .vout_high   (vout_high),
    .vout_low    (vout_low),
    .burst_active(burst_active),
    .burst_done  (burst_done),
    .pulse_go    (pulse_go)
  );

  pfm_switch_map map_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase_q(phase_q),
    .mode_q (mode_q),
    .sw_a   (sw_a),
    .sw_b   (sw_b),
    .sw_c   (sw_c),
    .sw_d   (sw_d)
  );

  assert_idle_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |-> !sw_a && !sw_b && !sw_c);

  assert_buck_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !mode_q) |-> sw_d && !sw_c);

endmodule

// File: tb/pfm_burst_ctrl_tb_top.sv
module pfm_burst_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_boost = 1'b1;
  logic ipk_hit = 1'b0;
  logic izero = 1'b0;
  logic vout_high = 1'b0;
  logic vout_low = 1'b0;
  logic sw_a, sw_b, sw_c, sw_d, burst_active, pulse_done, burst_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pfm_burst_ctrl #(.DT_CYC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_boost(mode_boost), .ipk_hit(ipk_hit),
    .izero(izero), .vout_high(vout_high), .vout_low(vout_low),
    .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c), .sw_d(sw_d),
    .burst_active(burst_active), .pulse_done(pulse_done), .burst_done(burst_done)
  );

  // Row: {mode_boost, ipk_hit, izero, vout_high, vout_low, a, b, c, d, active, pulse_done, burst_done}
  // Expected outputs are those seen after the clock edge that samples the row's inputs (dead time 2).
  localparam int NV = 34;
  localparam logic [11:0] VEC [NV] = '{
    12'b10001_0000_100, 12'b10000_1010_100, 12'b10100_1010_100, 12'b11000_0000_100,
    12'b10000_0000_100, 12'b10000_0101_100, 12'b11000_0101_100, 12'b00000_0101_100,
    12'b10100_0000_110, 12'b10000_0000_100, 12'b10000_0000_100, 12'b10000_1010_100,
    12'b11000_0000_100, 12'b10000_0000_100, 12'b10000_0101_100, 12'b10100_0000_110,
    12'b10010_0000_100, 12'b10010_0000_100, 12'b10010_0000_001, 12'b10010_0000_000,
    12'b10000_0000_000, 12'b00000_0001_000, 12'b00000_0001_000, 12'b00000_0001_000,
    12'b00001_0001_100, 12'b00000_1001_100, 12'b01000_0001_100, 12'b00000_0001_100,
    12'b00000_0101_100, 12'b00100_0001_110, 12'b00010_0001_100, 12'b00010_0001_100,
    12'b00010_0001_001, 12'b00000_0001_000
  };

  function automatic string row_req(input int i);
    if (i == 0 || i == 24)       return "R2";
    if (i == 1)                  return "R5";
    if (i == 2 || i == 6)        return "R12";
    if (i >= 3 && i <= 5)        return "R6";
    if (i == 7)                  return "R11";
    if (i >= 8 && i <= 10)       return "R8";
    if (i >= 11 && i <= 15)      return "R9";
    if (i >= 16 && i <= 20)      return "R10";
    if (i >= 21 && i <= 23)      return "R11";
    if (i == 25)                 return "R3";
    if (i >= 26 && i <= 28)      return "R4";
    if (i == 29)                 return "R8";
    return "R10";
  endfunction

  function automatic logic [6:0] observed();
    return {sw_a, sw_b, sw_c, sw_d, burst_active, pulse_done, burst_done};
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    logic [6:0] got;
    got = observed();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got abcd/act/pd/bd=%b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 7'b0000_000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {mode_boost, ipk_hit, izero, vout_high, vout_low} = VEC[i][11:7];
      @(negedge clk);
      check(row_req(i), VEC[i][6:0]);
    end
    // Start a buck pulse, then reset it while A is closed (R1).
    {mode_boost, ipk_hit, izero, vout_high, vout_low} = 5'b00001;
    @(negedge clk);
    check("R2", 7'b0001_100);
    vout_low = 1'b0;
    @(negedge clk);
    check("R3", 7'b1001_100);
    rst_n = 1'b0;
    mode_boost = 1'b1;
    #1;
    check("R1", 7'b0000_000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 7'b0000_000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule